// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month and a two-digit year, plus a day-of-week counter. A slow tick input at 32.768 kHz arrives as a one-cycle strobe in the system clock domain. A prescaler divides it down to one update per second. Each update carries through the fields in order, using the correct length for each month and a leap February whenever the year is a multiple of four.

Software reaches the block through a byte-wide register port that is word-spaced. It can load any time field directly, program a full alarm time, start and stop the clock through a control register, and enable two interrupts. One interrupt is a single-cycle pulse once per second. The other is a level that follows a sticky alarm flag. A status register holds sticky event flags that software clears by writing a 1 to them. The same register shows the run state and a busy flag. The busy flag is high during the last tick period before each update, and software should wait for it to drop before touching the time registers.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, the control register reads 0x00 and the status register reads 0x80, with only the power-up flag (bit 7) set.
- R2: Control bit 0 is the run enable. While it is 0, ticks leave the time unchanged. Status bit 1 mirrors it.
- R3: While running, the seconds field advances by one after every PRESCALE ticks. A BCD units digit of 9 carries into the tens digit, and 0x59 wraps to 0x00 and increments the minutes. Each advance sets status bit 2, and a minute carry also sets status bit 3.
- R4: Hours wrap from 0x23 to 0x00 and advance the day. An hour carry sets status bit 4, and a day carry sets status bit 5.
- R5: The day wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February. The month then advances.
- R6: February ends after day 0x29 when the BCD year value is divisible by four, and after day 0x28 otherwise.
- R7: Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R8: The day-of-week register (offset 0x18) counts 0 to 6 on each day carry and wraps back to 0 after 6.
- R9: Status bit 6 (alarm) is set on an update only when all six alarm fields (offsets 0x20 to 0x34, in the same field order as the time at 0x00 to 0x14) equal the new time. A difference in any one field, the year included, prevents it.
- R10: Status bits 7 to 2 are sticky. Writing 1 to a bit position at offset 0x44 clears that bit, and writing 0 has no effect on it.
- R11: Interrupt-enable register 0x48: bit 3 gates the alarm output (a level equal to status bit 6 AND the enable), and bit 2 gates the timer output, which pulses for one clock after each seconds update.
- R12: Status bit 0 (busy) is high while running with the prescaler in its last tick period before an update. Writing the seconds register clears the prescaler and drops busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq_timer | output | 1 | One-cycle pulse per seconds update when enabled |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The hardest states to reach are the carries that pass through several fields in one update: a leap or non-leap February end, a 30-day month end, and the end of year 99. Waiting for them in real time is impractical. The stimulus therefore loads the whole time one second before the boundary, writing seconds last so that the prescaler starts aligned. It then issues exactly PRESCALE ticks. Busy is reached by issuing one tick fewer than the prescale count, and the alarm is reached by loading a time one second short of the programmed alarm.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;
   localparam int NFIELD = 6;
   localparam int F_SEC  = 0;
   localparam int F_MIN  = 1;
   localparam int F_HR   = 2;
   localparam int F_DAY  = 3;
   localparam int F_MON  = 4;
   localparam int F_YR   = 5;

   typedef logic [NFIELD-1:0][7:0] cal_vec_t;

   // reset time: year 00, month 01, day 01, 00:00:00
   localparam cal_vec_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   localparam logic [6:0] OFS_WEEK = 7'h18;
   localparam logic [6:0] OFS_CTRL = 7'h40;
   localparam logic [6:0] OFS_STAT = 7'h44;
   localparam logic [6:0] OFS_IEN  = 7'h48;

   // one BCD step with wrap to zero at or above lim
   function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] lim);
      if (v >= lim)
         return 8'h00;
      else if (v[3:0] >= 4'd9)
         return {v[7:4] + 4'd1, 4'h0};
      else
         return v + 8'd1;
   endfunction

   // last day of the month, BCD
   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      logic [7:0] yb;
      yb = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
      case (mon)
         8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/bcd_cal_prescale.sv
`timescale 1ns/1ps
module bcd_cal_prescale #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic clr,
   output logic sec_stb,
   output logic busy
);
   localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign sec_stb = run & tick & at_last;
   assign busy    = run & at_last;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (run && tick)
         cnt_q <= at_last ? '0 : cnt_q + CW'(1);
   end
endmodule

// File: rtl/bcd_cal_count.sv
`timescale 1ns/1ps
module bcd_cal_count
   import bcd_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [NFIELD-1:0] fld_we,
   input  logic              week_we,
   input  logic [7:0]        wdata,
   output cal_vec_t          now_q,
   output cal_vec_t          nxt,
   output logic [7:0]        week_q,
   output logic              c_sec,
   output logic              c_min,
   output logic              c_hr
);
   logic c_day, c_mon;

   always_comb begin
      c_sec = (now_q[F_SEC] >= 8'h59);
      c_min = c_sec && (now_q[F_MIN] >= 8'h59);
      c_hr  = c_min && (now_q[F_HR]  >= 8'h23);
      c_day = c_hr  && (now_q[F_DAY] >= month_last(now_q[F_MON], now_q[F_YR]));
      c_mon = c_day && (now_q[F_MON] >= 8'h12);

      nxt        = now_q;
      nxt[F_SEC] = bcd_step(now_q[F_SEC], 8'h59);
      if (c_sec) nxt[F_MIN] = bcd_step(now_q[F_MIN], 8'h59);
      if (c_min) nxt[F_HR]  = bcd_step(now_q[F_HR], 8'h23);
      if (c_hr)  nxt[F_DAY] = c_day ? 8'h01 : bcd_step(now_q[F_DAY], 8'h31);
      if (c_day) nxt[F_MON] = c_mon ? 8'h01 : bcd_step(now_q[F_MON], 8'h12);
      if (c_mon) nxt[F_YR]  = bcd_step(now_q[F_YR], 8'h99);
   end

   for (genvar i = 0; i < NFIELD; i++) begin : g_fld
      always_ff @(posedge clk) begin
         if (!rst_n)
            now_q[i] <= CAL_RESET[i];
         else if (fld_we[i])
            now_q[i] <= wdata;
         else if (step)
            now_q[i] <= nxt[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         week_q <= 8'h00;
      else if (week_we)
         week_q <= wdata;
      else if (step && c_hr)
         week_q <= (week_q >= 8'h06) ? 8'h00 : week_q + 8'h01;
   end
endmodule

// File: rtl/bcd_cal_alarm.sv
`timescale 1ns/1ps
module bcd_cal_alarm
   import bcd_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFIELD-1:0] alm_we,
   input  logic [7:0]        wdata,
   input  cal_vec_t          cand,
   output cal_vec_t          alarm_q,
   output logic              match
);
   logic [NFIELD-1:0] eq;

   for (genvar i = 0; i < NFIELD; i++) begin : g_alm
      always_ff @(posedge clk) begin
         if (!rst_n)
            alarm_q[i] <= 8'h00;
         else if (alm_we[i])
            alarm_q[i] <= wdata;
      end
      assign eq[i] = (alarm_q[i] == cand[i]);
   end

   assign match = &eq;
endmodule

// File: rtl/bcd_calendar.sv
`timescale 1ns/1ps
module bcd_calendar
   import bcd_cal_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int PRESCALE = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              irq_timer,
   output logic              irq_alarm
);
   if (PRESCALE < 2) begin : g_bad_pre
      $error("bcd_calendar: PRESCALE must be at least 2");
   end
   if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_aw
      $error("bcd_calendar: ADDR_W must lie in 7..32");
   end

   // ---------------- address decode ----------------
   logic [6:0] a7;
   logic       hi_zero;
   logic [2:0] idx;
   logic       aligned, time_hit, alm_hit, week_hit, ctrl_hit, stat_hit, ien_hit;

   assign a7 = addr[6:0];
   if (ADDR_W > 7) begin : g_hi
      assign hi_zero = ~|addr[ADDR_W-1:7];
   end else begin : g_nohi
      assign hi_zero = 1'b1;
   end

   assign idx      = a7[4:2];
   assign aligned  = (a7[1:0] == 2'b00);
   assign time_hit = hi_zero & aligned & (a7[6:5] == 2'b00) & (idx < 3'd6);
   assign alm_hit  = hi_zero & aligned & (a7[6:5] == 2'b01) & (idx < 3'd6);
   assign week_hit = hi_zero & (a7 == OFS_WEEK);
   assign ctrl_hit = hi_zero & (a7 == OFS_CTRL);
   assign stat_hit = hi_zero & (a7 == OFS_STAT);
   assign ien_hit  = hi_zero & (a7 == OFS_IEN);

   logic [NFIELD-1:0] fld_we, alm_we;
   for (genvar i = 0; i < NFIELD; i++) begin : g_we
      assign fld_we[i] = wr_en & time_hit & (idx == 3'(i));
      assign alm_we[i] = wr_en & alm_hit  & (idx == 3'(i));
   end
   logic week_we, ctrl_we, stat_we, ien_we;
   assign week_we = wr_en & week_hit;
   assign ctrl_we = wr_en & ctrl_hit;
   assign stat_we = wr_en & stat_hit;
   assign ien_we  = wr_en & ien_hit;

   // ---------------- control / enables ----------------
   logic [7:0] ctrl_q;
   logic       ien_alarm, ien_timer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= 8'h00;
         ien_alarm <= 1'b0;
         ien_timer <= 1'b0;
      end else begin
         if (ctrl_we) ctrl_q <= wdata;
         if (ien_we) begin
            ien_alarm <= wdata[3];
            ien_timer <= wdata[2];
         end
      end
   end

   // ---------------- datapath ----------------
   logic     sec_stb, busy, upd;
   cal_vec_t now_q, nxt, alarm_q;
   logic [7:0] week_q;
   logic     c_sec, c_min, c_hr, hit;

   bcd_cal_prescale #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .tick(tick),
      .clr(fld_we[F_SEC]), .sec_stb(sec_stb), .busy(busy));

   // a bus write to the calendar in the same cycle wins over the update
   assign upd = sec_stb & ~(|fld_we) & ~week_we;

   bcd_cal_count u_cnt (
      .clk(clk), .rst_n(rst_n), .step(upd), .fld_we(fld_we), .week_we(week_we),
      .wdata(wdata), .now_q(now_q), .nxt(nxt), .week_q(week_q),
      .c_sec(c_sec), .c_min(c_min), .c_hr(c_hr));

   bcd_cal_alarm u_alm (
      .clk(clk), .rst_n(rst_n), .alm_we(alm_we), .wdata(wdata),
      .cand(nxt), .alarm_q(alarm_q), .match(hit));

   // ---------------- sticky status ----------------
   logic st_pu, st_alarm, st_day, st_hr, st_min, st_sec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_pu    <= 1'b1;
         st_alarm <= 1'b0;
         st_day   <= 1'b0;
         st_hr    <= 1'b0;
         st_min   <= 1'b0;
         st_sec   <= 1'b0;
      end else begin
         st_pu    <= st_pu & ~(stat_we & wdata[7]);
         st_alarm <= (upd & hit)   | (st_alarm & ~(stat_we & wdata[6]));
         st_day   <= (upd & c_hr)  | (st_day   & ~(stat_we & wdata[5]));
         st_hr    <= (upd & c_min) | (st_hr    & ~(stat_we & wdata[4]));
         st_min   <= (upd & c_sec) | (st_min   & ~(stat_we & wdata[3]));
         st_sec   <= upd           | (st_sec   & ~(stat_we & wdata[2]));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_timer <= 1'b0;
      else
         irq_timer <= upd & ien_timer;
   end

   assign irq_alarm = st_alarm & ien_alarm;

   // ---------------- read mux ----------------
   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NFIELD; i++) begin
         if (time_hit && idx == 3'(i)) rdata = now_q[i];
         if (alm_hit  && idx == 3'(i)) rdata = alarm_q[i];
      end
      if (week_hit) rdata = week_q;
      if (ctrl_hit) rdata = ctrl_q;
      if (stat_hit) rdata = {st_pu, st_alarm, st_day, st_hr, st_min, st_sec, ctrl_q[0], busy};
      if (ien_hit)  rdata = {4'b0000, ien_alarm, ien_timer, 2'b00};
   end
endmodule

// File: rtl/bcd_calendar_chk.sv
`timescale 1ns/1ps
module bcd_calendar_chk
   import bcd_cal_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic              run,
   input logic              busy,
   input cal_vec_t          now_q,
   input cal_vec_t          alarm_q,
   input logic              st_sec,
   input logic              st_alarm,
   input logic              st_pu,
   input logic              irq_timer,
   input logic              ien_timer
);
   assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(now_q));

   assert_sec_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (now_q[F_SEC][3:0] <= 4'd9) && (now_q[F_SEC] <= 8'h59));

   assert_alarm_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_alarm) |-> (now_q == alarm_q));

   assert_pu_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_pu) |-> $past(wr_en && addr == ADDR_W'(8'h44) && wdata[7]));

   assert_timer_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_timer |=> !irq_timer);

   assert_timer_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_timer |-> $past(ien_timer));

   assert_busy_before_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_sec) |-> $past(busy));
endmodule

bind bcd_calendar bcd_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .run(ctrl_q[0]), .busy(busy), .now_q(now_q), .alarm_q(alarm_q),
   .st_sec(st_sec), .st_alarm(st_alarm), .st_pu(st_pu),
   .irq_timer(irq_timer), .ien_timer(ien_timer));

// File: tb/bcd_calendar_test.sv
`timescale 1ns/1ps
module bcd_calendar_test;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] addr = 8'h00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq_timer, irq_alarm;

   bcd_calendar #(.ADDR_W(8), .PRESCALE(P)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_timer(irq_timer), .irq_alarm(irq_alarm));

   initial forever #10 clk = ~clk;

   typedef struct {
      int         kind;   // 0 register read, 1 irq_alarm, 2 timer pulse count
      logic [7:0] exp;
      logic [7:0] mask;
      string      tag;
   } item_t;

   item_t q[$];
   int    compared = 0;
   int    mismatched = 0;
   int    tcnt = 0;
   logic  rd_go = 1'b0;
   logic  done = 1'b0;

   // monitor: compares results against the scoreboard queue
   initial forever begin
      @(posedge clk);
      #5;
      if (rd_go && q.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it = q.pop_front();
         case (it.kind)
            0:       act = rdata;
            1:       act = {7'b0, irq_alarm};
            default: act = tcnt[7:0];
         endcase
         compared++;
         if ((act & it.mask) != (it.exp & it.mask)) begin
            mismatched++;
            $display("FAIL %s: actual %02h expected %02h (mask %02h)", it.tag, act, it.exp, it.mask);
         end
      end
   end

   initial forever begin
      @(negedge clk);
      if (irq_timer === 1'b1) tcnt++;
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_item(input int k, input logic [7:0] a, input logic [7:0] e,
                              input logic [7:0] m, input string tag);
      item_t it;
      it.kind = k; it.exp = e; it.mask = m; it.tag = tag;
      @(negedge clk);
      addr = a; rd_go = 1'b1;
      q.push_back(it);
      @(negedge clk);
      rd_go = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input logic [7:0] m, input string tag);
      expect_item(0, a, e, m, tag);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dy,
                           input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
      wr(8'h14, yr); wr(8'h10, mo); wr(8'h0C, dy);
      wr(8'h08, hr); wr(8'h04, mi); wr(8'h00, se);
   endtask

   task automatic chk_date(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dy, input string tag);
      rd_chk(8'h14, yr, 8'hFF, tag);
      rd_chk(8'h10, mo, 8'hFF, tag);
      rd_chk(8'h0C, dy, 8'hFF, tag);
   endtask

   // watchdog
   initial begin
      #4_000_000;
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_chk(8'h00, 8'h00, 8'hFF, "R1 sec");
      rd_chk(8'h04, 8'h00, 8'hFF, "R1 min");
      rd_chk(8'h08, 8'h00, 8'hFF, "R1 hr");
      chk_date(8'h00, 8'h01, 8'h01, "R1 date");
      rd_chk(8'h40, 8'h00, 8'hFF, "R1 ctrl");
      rd_chk(8'h44, 8'h80, 8'hFF, "R1 status");

      // R2 stopped clock ignores ticks
      ticks(2 * P);
      rd_chk(8'h00, 8'h00, 8'hFF, "R2 stopped sec");
      rd_chk(8'h44, 8'h00, 8'h02, "R2 run bit low");
      wr(8'h40, 8'h01);
      rd_chk(8'h44, 8'h02, 8'h02, "R2 run bit high");

      // R10 write-0 no effect, write-1 clears power-up
      wr(8'h44, 8'h00);
      rd_chk(8'h44, 8'h80, 8'h80, "R10 pu kept");
      wr(8'h44, 8'h80);
      rd_chk(8'h44, 8'h00, 8'h80, "R10 pu cleared");

      // R12 busy window and prescaler clear
      ticks(P - 1);
      rd_chk(8'h44, 8'h01, 8'h01, "R12 busy high");
      rd_chk(8'h00, 8'h00, 8'hFF, "R12 no update yet");
      ticks(1);
      rd_chk(8'h00, 8'h01, 8'hFF, "R3 first second");
      rd_chk(8'h44, 8'h04, 8'h05, "R3 sec event, busy low");
      ticks(P - 1);
      wr(8'h00, 8'h01);
      rd_chk(8'h44, 8'h00, 8'h01, "R12 busy cleared by sec write");
      ticks(P - 1);
      rd_chk(8'h00, 8'h01, 8'hFF, "R12 prescaler restarted");
      ticks(1);
      rd_chk(8'h00, 8'h02, 8'hFF, "R12 update after restart");

      // R3 BCD carries
      wr(8'h00, 8'h09);
      ticks(P);
      rd_chk(8'h00, 8'h10, 8'hFF, "R3 digit carry");
      wr(8'h44, 8'h3C);
      wr(8'h04, 8'h00);
      wr(8'h00, 8'h59);
      ticks(P);
      rd_chk(8'h00, 8'h00, 8'hFF, "R3 sec wrap");
      rd_chk(8'h04, 8'h01, 8'hFF, "R3 minute carry");
      rd_chk(8'h44, 8'h0C, 8'h3C, "R3 minute event");
      wr(8'h44, 8'h08);
      rd_chk(8'h44, 8'h04, 8'h0C, "R10 selective clear");

      // R4 / R8 hour and day carry
      wr(8'h44, 8'h3C);
      wr(8'h18, 8'h03);
      set_time(8'h25, 8'h06, 8'h15, 8'h23, 8'h59, 8'h59);
      ticks(P);
      rd_chk(8'h08, 8'h00, 8'hFF, "R4 hour wrap");
      rd_chk(8'h04, 8'h00, 8'hFF, "R4 minute wrap");
      chk_date(8'h25, 8'h06, 8'h16, "R4 day advance");
      rd_chk(8'h44, 8'h3C, 8'h3C, "R4 all events");
      rd_chk(8'h18, 8'h04, 8'hFF, "R8 weekday step");
      wr(8'h18, 8'h06);
      set_time(8'h25, 8'h06, 8'h16, 8'h23, 8'h59, 8'h59);
      ticks(P);
      rd_chk(8'h18, 8'h00, 8'hFF, "R8 weekday wrap");

      // R5 month lengths
      set_time(8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
      ticks(P);
      chk_date(8'h25, 8'h05, 8'h01, "R5 30-day month end");
      set_time(8'h25, 8'h05, 8'h30, 8'h23, 8'h59, 8'h59);
      ticks(P);
      chk_date(8'h25, 8'h05, 8'h31, "R5 31-day month no wrap");

      // R6 leap years
      set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      ticks(P);
      chk_date(8'h24, 8'h02, 8'h29, "R6 leap Feb 29");
      set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
      ticks(P);
      chk_date(8'h24, 8'h03, 8'h01, "R6 leap Feb end");
      set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      ticks(P);
      chk_date(8'h23, 8'h03, 8'h01, "R6 common Feb end");

      // R7 year wrap
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
      ticks(P);
      chk_date(8'h00, 8'h01, 8'h01, "R7 century wrap");

      // R9 alarm
      wr(8'h34, 8'h25); wr(8'h30, 8'h07); wr(8'h2C, 8'h04);
      wr(8'h28, 8'h12); wr(8'h24, 8'h00); wr(8'h20, 8'h00);
      rd_chk(8'h2C, 8'h04, 8'hFF, "R9 alarm readback");
      wr(8'h44, 8'h40);
      set_time(8'h26, 8'h07, 8'h04, 8'h11, 8'h59, 8'h59);
      ticks(P);
      rd_chk(8'h44, 8'h00, 8'h40, "R9 year differs, no alarm");
      set_time(8'h25, 8'h07, 8'h04, 8'h11, 8'h59, 8'h59);
      ticks(P);
      rd_chk(8'h44, 8'h40, 8'h40, "R9 alarm fires");
      expect_item(1, 8'h00, 8'h00, 8'h01, "R11 alarm irq masked");
      wr(8'h48, 8'h08);
      rd_chk(8'h48, 8'h08, 8'hFF, "R11 enable readback");
      expect_item(1, 8'h00, 8'h01, 8'h01, "R11 alarm irq on");
      wr(8'h44, 8'h40);
      expect_item(1, 8'h00, 8'h00, 8'h01, "R11 alarm irq cleared");
      ticks(P);
      rd_chk(8'h44, 8'h00, 8'h40, "R9 no refire");

      // R11 timer pulses
      wr(8'h48, 8'h04);
      @(negedge clk); tcnt = 0;
      ticks(3 * P);
      expect_item(2, 8'h00, 8'd3, 8'hFF, "R11 three timer pulses");
      wr(8'h48, 8'h00);
      ticks(2 * P);
      expect_item(2, 8'h00, 8'd3, 8'hFF, "R11 timer masked");

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule